// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable counter of the kind a performance-monitoring unit holds. Every clock it sees a small per-cycle count for each of several sub-events of several events, the privilege level of the code that is running, and a flag saying the core is halted. A 32-bit configuration word picks one event and any mix of its sub-events. The word also holds a threshold, an invert bit, an edge bit, two privilege filters, an enable and an interrupt enable. The per-cycle sum of the chosen sub-events goes through the threshold compare, the inversion and the edge detector, then through the privilege and halt gate, and is then added to a 48-bit counter.

Software uses a small register port. It writes the configuration, reads or loads the counter, and reads or clears a sticky overflow flag. The flag drives the interrupt output. A configuration write takes effect from the next cycle, so the cycle of the write still counts under the old settings. All register reads are combinational from the address. The counter and the flag change on the clock edge that ends the cycle in which their inputs were presented.

Top module: `qual_event_counter`

## Requirements
- R1: Event input lane (e, s) sits at bits [(e*SUB_NUM+s)*SUB_W +: SUB_W] of `ev_cnt_i`. The configuration word holds the event select in bits [7:0], of which only the low log2(EV_NUM) bits are used, and the sub-event mask in bits [15:8]. With threshold 0, the counter adds each cycle the sum of the lanes of the selected event whose mask bit is set. Lanes of other events have no effect.
- R2: The threshold is in bits [31:24]. When it is nonzero and invert (bit 20) is clear, the counter adds exactly 1 in a cycle whose sum is greater than or equal to the threshold, and 0 otherwise.
- R3: When the threshold is nonzero and invert is set, the counter adds 1 in a cycle whose sum is below the threshold, and 0 otherwise.
- R4: When the edge bit (bit 19) is set and the threshold is nonzero, the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous enabled cycle. The condition history follows the condition in every enabled cycle, whatever the privilege level or halt state.
- R5: Counting is allowed at privilege level 0 only if bit 17 is set, and at levels 1 to 3 only if bit 18 is set. No count is made in any cycle where `halted_i` is high.
- R6: While the enable bit (bit 16) is clear, the counter holds its value and the condition history is forced false. A condition that is already true in the first enabled cycle therefore counts once in edge mode.
- R7: Register address 0 is the configuration word (all 32 bits read back), address 1 is the counter, address 2 is the status word with the overflow flag in bit 0, and address 3 reads as zero. A counter write loads `reg_wdata_i` and takes priority over an increment in the same cycle.
- R8: When an increment carries the counter past all ones and interrupt enable (bit 21) is set, the sticky overflow flag is set and `irq_o` stays high. A status write with bit 0 set clears the flag, but a new overflow in the same cycle wins. With interrupt enable clear, a wrap leaves the flag unchanged.
- R9: After reset the configuration word, the counter and the overflow flag are zero, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_cnt_i | input | EV_NUM*SUB_NUM*SUB_W | Per-cycle sub-event counts, one lane per event and sub-event |
| priv_i | input | 2 | Current privilege level, 0 is most privileged |
| halted_i | input | 1 | Core halted; suppresses counting |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 config, 1 counter, 2 status |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Overflow interrupt, high while the sticky flag is set |

## Verification
The hardest situation to reach is an overflow that lands in the same cycle as a status-clear write, or in a cycle where the edge history and the privilege gate disagree. Counting up from reset would take far too long to reach the 48-bit wrap. So the stimulus loads the counter to a few counts below all ones and then feeds large per-cycle sums. The random phase mixes configuration rewrites, loads near the wrap, status clears, halted cycles and privilege changes. Every cycle's read result and interrupt level is compared against a model built from the requirements.

// File: rtl/qec_pkg.sv
package qec_pkg;

    localparam int EV_NUM  = 4;
    localparam int SUB_NUM = 4;
    localparam int SUB_W   = 3;
    localparam int CNT_W   = 48;

    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_CNT  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // Configuration word, MSB first
    typedef struct packed {
        logic [7:0] cmask;
        logic [1:0] spare;
        logic       ie;
        logic       inv;
        logic       edge_en;
        logic       usr;
        logic       os;
        logic       en;
        logic [7:0] umask;
        logic [7:0] evsel;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    function automatic logic priv_ok(input cfg_t c, input logic [1:0] pv);
        return (pv == 2'd0) ? c.os : c.usr;
    endfunction

endpackage

// File: rtl/qec_select.sv
module qec_select #(
    parameter int EV_NUM  = 4,
    parameter int SUB_NUM = 4,
    parameter int SUB_W   = 3,
    parameter int SEL_W   = 2,
    parameter int SUM_W   = 5
) (
    input  logic [EV_NUM*SUB_NUM*SUB_W-1:0] ev_i,
    input  logic [SEL_W-1:0]                sel_i,
    input  logic [SUB_NUM-1:0]              umask_i,
    output logic [SUM_W-1:0]                sum_o
);
    localparam int GRP_W = SUB_NUM * SUB_W;

    logic [GRP_W-1:0] grp;
    logic [SUM_W-1:0] lane [SUB_NUM];

    always_comb begin
        grp = ev_i[int'(sel_i)*GRP_W +: GRP_W];
    end

    generate
        for (genvar s = 0; s < SUB_NUM; s++) begin : g_lane
            assign lane[s] = umask_i[s] ? SUM_W'(grp[s*SUB_W +: SUB_W]) : '0;
        end
    endgenerate

    always_comb begin
        sum_o = '0;
        for (int s = 0; s < SUB_NUM; s++) begin
            sum_o = sum_o + lane[s];
        end
    end

endmodule

// File: rtl/qec_qualify.sv
module qec_qualify
    import qec_pkg::*;
#(
    parameter int SUM_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg_i,
    input  logic [SUM_W-1:0] sum_i,
    input  logic [1:0]       priv_i,
    input  logic             halted_i,
    output logic [SUM_W-1:0] inc_o
);
    localparam int CMP_W = (SUM_W > 8) ? SUM_W : 8;

    logic             hist_q;
    logic             cond;
    logic             pulse;
    logic             allow;
    logic             thresholded;
    logic [SUM_W-1:0] raw;

    always_comb begin
        thresholded = (cfg_i.cmask != 8'd0);
        if (cfg_i.inv) cond = CMP_W'(sum_i) <  CMP_W'(cfg_i.cmask);
        else           cond = CMP_W'(sum_i) >= CMP_W'(cfg_i.cmask);
        pulse = cfg_i.edge_en ? (cond & ~hist_q) : cond;
        raw   = thresholded ? SUM_W'(pulse) : sum_i;
        allow = cfg_i.en & ~halted_i & priv_ok(cfg_i, priv_i);
        inc_o = allow ? raw : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)            hist_q <= 1'b0;
        else if (cfg_i.en)  hist_q <= cond;
        else                hist_q <= 1'b0;
    end

    // R2: a thresholded event never adds more than one per cycle
    assert_thresh_single_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.cmask != 8'd0) |-> (inc_o <= SUM_W'(1)));

    // R4: no count while the condition was already true last cycle
    assert_edge_once_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.edge_en && cfg_i.cmask != 8'd0 && hist_q) |-> (inc_o == '0));

    // R5: filtered privilege levels and halted cycles never count
    assert_priv_block_R5: assert property (@(posedge clk) disable iff (rst)
        (halted_i || (priv_i == 2'd0 && !cfg_i.os) || (priv_i != 2'd0 && !cfg_i.usr))
        |-> (inc_o == '0));

endmodule

// File: rtl/qec_accum.sv
module qec_accum #(
    parameter int CNT_W = 48,
    parameter int INC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             ie_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic [CNT_W:0]   nxt;
    logic             wrap;

    always_comb begin
        nxt  = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);
        wrap = nxt[CNT_W] & ~ld_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            cnt_q <= ld_i ? ld_val_i : nxt[CNT_W-1:0];
            if (wrap && ie_i)  flag_q <= 1'b1;
            else if (clr_i)    flag_q <= 1'b0;
        end
    end

    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;

    // R7: a load wins over any increment of the same cycle
    assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
        ld_i |=> (cnt_q == $past(ld_val_i)));

    // R8: the flag only rises while interrupt enable was set
    assert_flag_needs_ie_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(ie_i));

    // R8: flag stays set unless a clear was requested
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
    import qec_pkg::*;
#(
    parameter int EV_NUM  = qec_pkg::EV_NUM,
    parameter int SUB_NUM = qec_pkg::SUB_NUM,
    parameter int SUB_W   = qec_pkg::SUB_W,
    parameter int CNT_W   = qec_pkg::CNT_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [EV_NUM*SUB_NUM*SUB_W-1:0] ev_cnt_i,
    input  logic [1:0]                      priv_i,
    input  logic                            halted_i,
    input  logic                            reg_wr_i,
    input  logic [1:0]                      reg_addr_i,
    input  logic [CNT_W-1:0]                reg_wdata_i,
    output logic [CNT_W-1:0]                reg_rdata_o,
    output logic                            irq_o
);
    localparam int SEL_W = (EV_NUM > 1) ? $clog2(EV_NUM) : 1;
    localparam int SUM_W = SUB_W + ((SUB_NUM > 1) ? $clog2(SUB_NUM) : 1);

    cfg_t             cfg_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] inc;
    logic [CNT_W-1:0] cnt;
    logic             flag;
    logic             wr_cfg, wr_cnt, wr_stat;
    reg_sel_e         rsel;

    always_comb begin
        rsel    = reg_sel_e'(reg_addr_i);
        wr_cfg  = reg_wr_i && (rsel == REG_CFG);
        wr_cnt  = reg_wr_i && (rsel == REG_CNT);
        wr_stat = reg_wr_i && (rsel == REG_STAT);
    end

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (wr_cfg) cfg_q <= cfg_t'(reg_wdata_i[CFG_W-1:0]);
    end

    qec_select #(
        .EV_NUM (EV_NUM),
        .SUB_NUM(SUB_NUM),
        .SUB_W  (SUB_W),
        .SEL_W  (SEL_W),
        .SUM_W  (SUM_W)
    ) u_select (
        .ev_i   (ev_cnt_i),
        .sel_i  (cfg_q.evsel[SEL_W-1:0]),
        .umask_i(cfg_q.umask[SUB_NUM-1:0]),
        .sum_o  (sum)
    );

    qec_qualify #(
        .SUM_W(SUM_W)
    ) u_qualify (
        .clk     (clk),
        .rst     (rst),
        .cfg_i   (cfg_q),
        .sum_i   (sum),
        .priv_i  (priv_i),
        .halted_i(halted_i),
        .inc_o   (inc)
    );

    qec_accum #(
        .CNT_W(CNT_W),
        .INC_W(SUM_W)
    ) u_accum (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (inc),
        .ld_i    (wr_cnt),
        .ld_val_i(reg_wdata_i),
        .ie_i    (cfg_q.ie),
        .clr_i   (wr_stat && reg_wdata_i[0]),
        .cnt_o   (cnt),
        .flag_o  (flag)
    );

    always_comb begin
        case (rsel)
            REG_CFG:  reg_rdata_o = CNT_W'(cfg_q);
            REG_CNT:  reg_rdata_o = cnt;
            REG_STAT: reg_rdata_o = CNT_W'(flag);
            default:  reg_rdata_o = '0;
        endcase
    end

    assign irq_o = flag;

    // R6: a disabled counter without a load keeps its value
    assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.en && !wr_cnt) |=> $stable(cnt));

    // R7: a configuration write is visible on the next cycle
    assert_cfg_write_R7: assert property (@(posedge clk) disable iff (rst)
        wr_cfg |=> (cfg_q == cfg_t'($past(reg_wdata_i[CFG_W-1:0]))));

endmodule

// File: tb/qual_event_counter_bench.sv
module qual_event_counter_bench;
    import qec_pkg::*;

    localparam int EVW = EV_NUM * SUB_NUM * SUB_W;
    localparam int CW  = CNT_W;
    localparam logic [CW-1:0] ONES = '1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [EVW-1:0] ev  = '0;
    logic [1:0]     pv  = 2'd0;
    logic           hl  = 1'b0;
    logic           wr  = 1'b0;
    logic [1:0]     addr = 2'd0;
    logic [CW-1:0]  wd  = '0;
    logic [CW-1:0]  rdata;
    logic           irq;

    always #2.5ns clk = ~clk;

    qual_event_counter u_qual_event_counter (
        .clk(clk), .rst(rst), .ev_cnt_i(ev), .priv_i(pv), .halted_i(hl),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wd),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    typedef struct {
        logic [CW-1:0] exp;
        logic          exp_irq;
        logic [1:0]    a;
        string         tag;
    } item_t;

    item_t sbq[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;

    logic [31:0]   m_cfg  = '0;
    logic [CW-1:0] m_cnt  = '0;
    logic          m_hist = 1'b0;
    logic          m_flag = 1'b0;

    function automatic logic [EVW-1:0] ev_set(int sel, int v0, int v1, int v2, int v3);
        logic [EVW-1:0] r = '0;
        r[(sel*SUB_NUM+0)*SUB_W +: SUB_W] = SUB_W'(v0);
        r[(sel*SUB_NUM+1)*SUB_W +: SUB_W] = SUB_W'(v1);
        r[(sel*SUB_NUM+2)*SUB_W +: SUB_W] = SUB_W'(v2);
        r[(sel*SUB_NUM+3)*SUB_W +: SUB_W] = SUB_W'(v3);
        return r;
    endfunction

    function automatic logic [31:0] mk_cfg(int sel, int um, int cm, bit en, bit os,
                                           bit usr, bit ed, bit iv, bit ie);
        return {8'(cm), 2'b00, ie, iv, ed, usr, os, en, 8'(um), 8'(sel)};
    endfunction

    // Driver: one clock cycle of stimulus plus the model's expectation
    task automatic cyc(input logic w, input logic [1:0] a, input logic [CW-1:0] d,
                       input logic [EVW-1:0] e, input logic [1:0] p, input logic h,
                       input string tag);
        int sel, sum, cm;
        bit en, os, usr, ed, iv, ie, cond, allow, set_now;
        longint inc;
        logic [CW:0] t;
        item_t it;
        @(negedge clk);
        wr = w; addr = a; wd = d; ev = e; pv = p; hl = h;
        sel = int'(m_cfg[7:0]) % EV_NUM;
        sum = 0;
        for (int s = 0; s < SUB_NUM; s++)
            if (m_cfg[8+s]) sum += int'(e[(sel*SUB_NUM+s)*SUB_W +: SUB_W]);
        cm = int'(m_cfg[31:24]);
        en = m_cfg[16]; os = m_cfg[17]; usr = m_cfg[18];
        ed = m_cfg[19]; iv = m_cfg[20]; ie = m_cfg[21];
        cond = iv ? (sum < cm) : (sum >= cm);
        if (cm == 0) inc = sum;
        else         inc = (ed ? (cond && !m_hist) : cond) ? 1 : 0;
        allow = en && !h && ((p == 2'd0) ? os : usr);
        if (!allow) inc = 0;
        m_hist = en ? cond : 1'b0;
        set_now = 0;
        if (w && a == 2'd1) m_cnt = d;
        else begin
            t = {1'b0, m_cnt} + (CW+1)'(inc);
            m_cnt = t[CW-1:0];
            if (t[CW] && ie) begin m_flag = 1'b1; set_now = 1; end
        end
        if (w && a == 2'd2 && d[0] && !set_now) m_flag = 1'b0;
        if (w && a == 2'd0) m_cfg = d[31:0];
        case (a)
            2'd0:    it.exp = CW'(m_cfg);
            2'd1:    it.exp = m_cnt;
            2'd2:    it.exp = CW'(m_flag);
            default: it.exp = '0;
        endcase
        it.exp_irq = m_flag;
        it.a = a;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: compare after each edge
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1ns;
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                total++;
                if (rdata !== it.exp || irq !== it.exp_irq) begin
                    bad++;
                    $display("FAIL %s: addr=%0d actual rdata=%h irq=%b expected rdata=%h irq=%b",
                             it.tag, it.a, rdata, irq, it.exp, it.exp_irq);
                end
            end
        end
    end

    task automatic chk_now(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    localparam logic [1:0] A_CFG = 2'd0, A_CNT = 2'd1, A_ST = 2'd2;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [EVW-1:0] z = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        addr = A_CFG; #0.5ns; chk_now("R9 cfg", rdata, '0);
        addr = A_CNT; #0.5ns; chk_now("R9 cnt", rdata, '0);
        addr = A_ST;  #0.5ns; chk_now("R9 flag", rdata, '0);
        chk_now("R9 irq", CW'(irq), '0);

        // R1 sub-event selection and summing
        cyc(1, A_CFG, CW'(mk_cfg(2, 4'b0101, 0, 1, 1, 1, 0, 0, 0)), z, 0, 0, "R1 cfg");
        cyc(0, A_CNT, '0, ev_set(2, 3, 7, 5, 1), 0, 0, "R1 sum of masked lanes");
        cyc(0, A_CNT, '0, ev_set(1, 7, 7, 7, 7), 0, 0, "R1 other event ignored");
        cyc(0, A_CNT, '0, ev_set(2, 0, 6, 2, 6), 1, 0, "R1 second pattern");
        cyc(1, A_CFG, CW'(mk_cfg(6, 4'b1111, 0, 1, 1, 1, 0, 0, 0)), z, 0, 0, "R1 cfg all lanes");
        cyc(0, A_CNT, '0, ev_set(2, 7, 7, 7, 7), 0, 0, "R1 select low bits");

        // R2 threshold
        cyc(1, A_CFG, CW'(mk_cfg(0, 4'b1111, 4, 1, 1, 1, 0, 0, 0)), z, 0, 0, "R2 cfg");
        cyc(0, A_CNT, '0, ev_set(0, 1, 1, 1, 0), 0, 0, "R2 below threshold");
        cyc(0, A_CNT, '0, ev_set(0, 1, 1, 1, 1), 0, 0, "R2 at threshold");
        cyc(0, A_CNT, '0, ev_set(0, 7, 2, 0, 0), 0, 0, "R2 above threshold");

        // R3 invert
        cyc(1, A_CFG, CW'(mk_cfg(0, 4'b1111, 4, 1, 1, 1, 0, 1, 0)), z, 0, 0, "R3 cfg");
        cyc(0, A_CNT, '0, ev_set(0, 3, 0, 0, 0), 0, 0, "R3 below counts");
        cyc(0, A_CNT, '0, ev_set(0, 4, 0, 0, 0), 0, 0, "R3 at threshold none");
        cyc(0, A_CNT, '0, z, 0, 0, "R3 zero counts");

        // R4 edge
        cyc(1, A_CFG, CW'(mk_cfg(0, 4'b0001, 1, 1, 1, 1, 1, 0, 0)), z, 0, 0, "R4 cfg");
        cyc(0, A_CNT, '0, ev_set(0, 1, 0, 0, 0), 0, 0, "R4 rising");
        cyc(0, A_CNT, '0, ev_set(0, 2, 0, 0, 0), 0, 0, "R4 held");
        cyc(0, A_CNT, '0, ev_set(0, 3, 0, 0, 0), 0, 0, "R4 held");
        cyc(0, A_CNT, '0, z, 0, 0, "R4 falls");
        cyc(0, A_CNT, '0, ev_set(0, 5, 0, 0, 0), 3, 1, "R4 rise while halted");
        cyc(0, A_CNT, '0, ev_set(0, 5, 0, 0, 0), 3, 0, "R4 history tracked while halted");

        // R5 privilege and halt
        cyc(1, A_CFG, CW'(mk_cfg(1, 4'b0011, 0, 1, 1, 0, 0, 0, 0)), z, 0, 0, "R5 cfg os");
        cyc(0, A_CNT, '0, ev_set(1, 2, 2, 0, 0), 2, 0, "R5 user level blocked");
        cyc(0, A_CNT, '0, ev_set(1, 2, 2, 0, 0), 0, 0, "R5 level 0 counts");
        cyc(0, A_CNT, '0, ev_set(1, 2, 2, 0, 0), 0, 1, "R5 halted blocked");
        cyc(1, A_CFG, CW'(mk_cfg(1, 4'b0011, 0, 1, 0, 1, 0, 0, 0)), z, 0, 0, "R5 cfg usr");
        cyc(0, A_CNT, '0, ev_set(1, 1, 2, 0, 0), 3, 0, "R5 level 3 counts");
        cyc(0, A_CNT, '0, ev_set(1, 1, 2, 0, 0), 0, 0, "R5 level 0 blocked");

        // R6 disable
        cyc(1, A_CFG, CW'(mk_cfg(0, 4'b0001, 1, 0, 1, 1, 1, 0, 0)), z, 0, 0, "R6 cfg off");
        cyc(0, A_CNT, '0, ev_set(0, 4, 0, 0, 0), 0, 0, "R6 holds");
        cyc(1, A_CFG, CW'(mk_cfg(0, 4'b0001, 1, 1, 1, 1, 1, 0, 0)), ev_set(0, 4, 0, 0, 0), 0, 0, "R6 cfg on");
        cyc(0, A_CNT, '0, ev_set(0, 4, 0, 0, 0), 0, 0, "R6 first enabled cycle counts");
        cyc(0, A_CNT, '0, ev_set(0, 4, 0, 0, 0), 0, 0, "R6 then held");

        // R7 register access and write priority
        cyc(1, A_CFG, CW'(mk_cfg(0, 4'b1111, 0, 1, 1, 1, 0, 0, 0)), z, 0, 0, "R7 cfg");
        cyc(1, A_CNT, CW'(48'h1234_5678_9ABC), ev_set(0, 7, 7, 7, 7), 0, 0, "R7 load beats increment");
        cyc(0, A_CNT, '0, ev_set(0, 1, 0, 0, 0), 0, 0, "R7 count after load");
        cyc(0, 2'd3, '0, z, 0, 0, "R7 unused address reads zero");
        cyc(0, A_CFG, '0, z, 0, 0, "R7 cfg read back");

        // R8 wrap and overflow flag
        cyc(1, A_CFG, CW'(mk_cfg(0, 4'b0011, 0, 1, 1, 1, 0, 0, 1)), z, 0, 0, "R8 cfg ie");
        cyc(1, A_CNT, ONES - 48'd1, z, 0, 0, "R8 load near wrap");
        cyc(0, A_CNT, '0, ev_set(0, 2, 1, 0, 0), 0, 0, "R8 wrap sets flag");
        cyc(0, A_ST, '0, z, 0, 0, "R8 flag sticky");
        cyc(1, A_ST, CW'(1), z, 0, 0, "R8 clear flag");
        cyc(1, A_CNT, ONES, z, 0, 0, "R8 load all ones");
        cyc(1, A_ST, CW'(1), ev_set(0, 1, 0, 0, 0), 0, 0, "R8 overflow beats clear");
        cyc(1, A_ST, CW'(1), z, 0, 0, "R8 clear again");
        cyc(1, A_CFG, CW'(mk_cfg(0, 4'b0011, 0, 1, 1, 1, 0, 0, 0)), z, 0, 0, "R8 cfg no ie");
        cyc(1, A_CNT, ONES, z, 0, 0, "R8 load all ones");
        cyc(0, A_ST, '0, ev_set(0, 3, 0, 0, 0), 0, 0, "R8 wrap without ie");

        // Random mix: R1 R2 R3 R4 R5 R6 R8
        for (int n = 0; n < 4000; n++) begin
            int k = int'($urandom_range(0, 99));
            logic [EVW-1:0] re;
            for (int b = 0; b < EVW; b++) re[b] = 1'($urandom);
            if (k < 4) begin
                logic [31:0] c;
                c = {8'($urandom_range(0, 6)), 2'($urandom), 6'($urandom),
                     8'($urandom), 8'($urandom)};
                c[16] = ($urandom_range(0, 9) != 0);
                cyc(1, A_CFG, CW'(c), re, 2'($urandom), ($urandom_range(0, 9) == 0), "R1 R2 R3 R4 random cfg");
            end else if (k < 7) begin
                cyc(1, A_CNT, ONES - CW'($urandom_range(0, 40)), re, 2'($urandom), 0, "R8 random load near wrap");
            end else if (k < 9) begin
                cyc(1, A_ST, CW'(1), re, 2'($urandom), 0, "R8 random clear");
            end else begin
                cyc(0, 2'($urandom_range(0, 2)), '0, re, 2'($urandom),
                    ($urandom_range(0, 9) == 0), "R5 R6 random stream");
            end
        end

        cyc(0, A_CNT, '0, z, 0, 0, "R7 final read");
        repeat (3) @(posedge clk);
        #2ns;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule